// File: doc/BRIEF.md
# Standalone Fault Autoretry Supervisor

This block switches an audio output channel off when that channel reports a destructive fault. It is used only when no serial host is present. While the channel is off, a retry timer counts a slow time-base tick. When the timer expires, the channel is switched back on for one tick to see whether the fault has cleared. If the fault is still there, the channel goes off again for another full interval. If the fault is gone, the channel stays on.

Two kinds of fault are handled. A short on a channel's output affects only that channel. A chip-wide fault, such as over-temperature shutdown or supply overvoltage, switches off every channel, and every channel then runs its own retry loop. Each fault event also drives an active-low fault indicator. The indicator is held low for a fixed number of ticks, and a new event restarts that count. In standalone operation none of this can be masked.

Standalone operation is selected when both address strap inputs are tied low. With any other strap value the supervisor is inactive: every channel is enabled, the indicator is released, and all timers are cleared.

Top module: `fault_retry_sup`

## Requirements
- R1: The block is active only when `addrStrap` equals 2'b00. For any other strap value, one cycle later `chanEn` is all ones and `flagN` is 1, whatever the fault inputs are.
- R2: In standalone operation, a high `chanFault[c]` on an enabled channel that is running normally drives `chanEn[c]` low one cycle later. Other channels are not affected.
- R3: Any set bit of `globalFault` disables every channel one cycle later.
- R4: A disabled channel stays off for exactly RETRY_TICKS `tick` pulses. It is re-enabled in the cycle after the RETRY_TICKS-th tick.
- R5: A re-enabled channel samples its fault at the next tick. If the fault is present, the channel goes off again for another RETRY_TICKS ticks. If it is absent, the channel stays on.
- R6: Every fault event drives `flagN` low one cycle later. A fault event is either a disable or a failed retry. `flagN` returns high in the cycle after the FLAG_TICKS-th tick that follows the last event.
- R7: A fault event while `flagN` is low restarts the FLAG_TICKS count.
- R8: After reset, `chanEn` is all ones and `flagN` is 1.
- R9: When the block leaves standalone operation in the middle of a retry interval, the channel is enabled at once and the timer is dropped. On return, a channel with no fault stays enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle time-base pulse (nominally 1 ms) |
| addrStrap | input | 2 | Address strap levels; 2'b00 selects standalone |
| chanFault | input | NCH | Per-channel output short (to supply or ground) |
| globalFault | input | NGLB | Chip-wide faults (thermal shutdown, overvoltage) |
| chanEn | output | NCH | Per-channel output enable |
| flagN | output | 1 | Active-low stretched fault indicator |

## Verification
The channel faults are first tried as a single-cycle blip. This separates the retry timer, which must run to expiry on its own, from the fault input. Next, each fault is held through zero, one and two retry attempts, which shows that a failed retry re-arms the full interval and that a cleared fault ends the loop. Each global fault bit is then applied alone, to show that it reaches both channels. Two overlapping events are spaced less than a pulse apart, which tells a restarted indicator from one that ends on its first count. Finally, every non-standalone strap value is applied with all faults raised, and the strap is released in the middle of a retry, to show that the block is inert and that its timers are dropped.

// File: rtl/afr_pkg.sv
package afr_pkg;

  typedef enum logic [1:0] {
    CH_ON       = 2'd0,
    CH_OFF_WAIT = 2'd1,
    CH_RETRY    = 2'd2
  } chanState_e;

  // per-channel retry timer strobes from control to datapath
  typedef struct packed {
    logic load;
    logic dec;
  } retryStb_t;

  // indicator timer strobes plus global clear
  typedef struct packed {
    logic load;
    logic tick;
    logic clearAll;
  } flagStb_t;

endpackage

// File: rtl/afr_timers.sv
module afr_timers
  import afr_pkg::*;
#(
  parameter int NCH         = 2,
  parameter int RETRY_TICKS = 500,
  parameter int FLAG_TICKS  = 100
) (
  input  logic                clk,
  input  logic                rstN,
  input  retryStb_t [NCH-1:0] chStb,
  input  flagStb_t            flagStb,
  output logic      [NCH-1:0] retryLast,
  output logic                flagActive
);

  localparam int RW = $clog2(RETRY_TICKS + 1);
  localparam int FW = $clog2(FLAG_TICKS + 1);
  localparam logic [RW-1:0] RETRY_LOAD = RW'(RETRY_TICKS);
  localparam logic [FW-1:0] FLAG_LOAD  = FW'(FLAG_TICKS);

  for (genvar gi = 0; gi < NCH; gi++) begin : g_retry
    logic [RW-1:0] retryCnt;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        retryCnt <= '0;
      end else if (flagStb.clearAll) begin
        retryCnt <= '0;
      end else if (chStb[gi].load) begin
        retryCnt <= RETRY_LOAD;
      end else if (chStb[gi].dec && (retryCnt != '0)) begin
        retryCnt <= retryCnt - 1'b1;
      end
    end

    assign retryLast[gi] = (retryCnt == RW'(1));
  end

  logic [FW-1:0] flagCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagCnt <= '0;
    end else if (flagStb.clearAll) begin
      flagCnt <= '0;
    end else if (flagStb.load) begin
      flagCnt <= FLAG_LOAD;
    end else if (flagStb.tick && (flagCnt != '0)) begin
      flagCnt <= flagCnt - 1'b1;
    end
  end

  assign flagActive = (flagCnt != '0);

endmodule

// File: rtl/afr_ctrl.sv
module afr_ctrl
  import afr_pkg::*;
#(
  parameter int NCH  = 2,
  parameter int NGLB = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tick,
  input  logic                standalone,
  input  logic      [NCH-1:0] chanFault,
  input  logic     [NGLB-1:0] globalFault,
  input  logic      [NCH-1:0] retryLast,
  output retryStb_t [NCH-1:0] chStb,
  output flagStb_t            flagStb,
  output logic      [NCH-1:0] chanEn
);

  logic           anyGlobal;
  logic [NCH-1:0] faultEvt;

  assign anyGlobal = |globalFault;

  for (genvar gi = 0; gi < NCH; gi++) begin : g_chan
    chanState_e state, stateNxt;
    retryStb_t  stbLoc;
    logic       evtLoc;
    logic       fault;

    assign fault = chanFault[gi] | anyGlobal;

    always_comb begin
      stateNxt = state;
      stbLoc   = '0;
      evtLoc   = 1'b0;
      if (!standalone) begin
        stateNxt = CH_ON;
      end else begin
        case (state)
          CH_ON: begin
            if (fault) begin
              stateNxt    = CH_OFF_WAIT;
              stbLoc.load = 1'b1;
              evtLoc      = 1'b1;
            end
          end
          CH_OFF_WAIT: begin
            if (tick) begin
              if (retryLast[gi]) stateNxt = CH_RETRY;
              else               stbLoc.dec = 1'b1;
            end
          end
          CH_RETRY: begin
            if (tick) begin
              if (fault) begin
                stateNxt    = CH_OFF_WAIT;
                stbLoc.load = 1'b1;
                evtLoc      = 1'b1;
              end else begin
                stateNxt = CH_ON;
              end
            end
          end
          default: stateNxt = CH_ON;
        endcase
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) state <= CH_ON;
      else       state <= stateNxt;
    end

    assign chStb[gi]    = stbLoc;
    assign faultEvt[gi] = evtLoc;
    assign chanEn[gi]   = (state != CH_OFF_WAIT);
  end

  assign flagStb.load     = |faultEvt;
  assign flagStb.tick     = tick;
  assign flagStb.clearAll = ~standalone;

endmodule

// File: rtl/fault_retry_sup.sv
module fault_retry_sup
  import afr_pkg::*;
#(
  parameter int NCH         = 2,
  parameter int NGLB        = 2,
  parameter int RETRY_TICKS = 500,
  parameter int FLAG_TICKS  = 100
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            tick,
  input  logic [1:0]      addrStrap,
  input  logic [NCH-1:0]  chanFault,
  input  logic [NGLB-1:0] globalFault,
  output logic [NCH-1:0]  chanEn,
  output logic            flagN
);

  logic                standalone;
  logic      [NCH-1:0] retryLast;
  logic                flagActive;
  retryStb_t [NCH-1:0] chStb;
  flagStb_t            flagStb;

  assign standalone = (addrStrap == 2'b00);

  afr_ctrl #(.NCH(NCH), .NGLB(NGLB)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .tick       (tick),
    .standalone (standalone),
    .chanFault  (chanFault),
    .globalFault(globalFault),
    .retryLast  (retryLast),
    .chStb      (chStb),
    .flagStb    (flagStb),
    .chanEn     (chanEn)
  );

  afr_timers #(.NCH(NCH), .RETRY_TICKS(RETRY_TICKS), .FLAG_TICKS(FLAG_TICKS)) i_timers (
    .clk       (clk),
    .rstN      (rstN),
    .chStb     (chStb),
    .flagStb   (flagStb),
    .retryLast (retryLast),
    .flagActive(flagActive)
  );

  assign flagN = ~flagActive;

endmodule

// File: rtl/fault_retry_sup_chk.sv
module fault_retry_sup_chk #(
  parameter int NCH  = 2,
  parameter int NGLB = 2
) (
  input logic            clk,
  input logic            rstN,
  input logic            tick,
  input logic [1:0]      addrStrap,
  input logic [NCH-1:0]  chanFault,
  input logic [NGLB-1:0] globalFault,
  input logic [NCH-1:0]  chanEn,
  input logic            flagN
);

  logic idleStrap;
  assign idleStrap = (addrStrap != 2'b00);

  a_r1_strap_forces_on: assert property (@(posedge clk) disable iff (!rstN)
    idleStrap |=> (&chanEn && flagN));

  a_r6_flag_ends_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagN) |-> ($past(tick) || $past(idleStrap)));

  for (genvar gi = 0; gi < NCH; gi++) begin : g_chk
    logic fault;
    assign fault = chanFault[gi] | (|globalFault);

    a_r2_fault_disables: assert property (@(posedge clk) disable iff (!rstN)
      (!idleStrap && chanEn[gi] && fault && tick) |=> !chanEn[gi]);

    a_r6_fault_lowers_flag: assert property (@(posedge clk) disable iff (!rstN)
      (!idleStrap && chanEn[gi] && fault && tick) |=> !flagN);

    a_r4_reenable_on_tick: assert property (@(posedge clk) disable iff (!rstN)
      $rose(chanEn[gi]) |-> ($past(tick) || $past(idleStrap)));
  end

endmodule

bind fault_retry_sup fault_retry_sup_chk #(.NCH(NCH), .NGLB(NGLB)) i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .tick       (tick),
  .addrStrap  (addrStrap),
  .chanFault  (chanFault),
  .globalFault(globalFault),
  .chanEn     (chanEn),
  .flagN      (flagN)
);

// File: tb/test_fault_retry_sup.sv
module test_fault_retry_sup;

  localparam int NCH = 2;
  localparam int NGLB = 2;
  localparam int RT = 5;
  localparam int FT = 3;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            tick = 1'b0;
  logic [1:0]      addrStrap = 2'b00;
  logic [NCH-1:0]  chanFault = '0;
  logic [NGLB-1:0] globalFault = '0;
  logic [NCH-1:0]  chanEn;
  logic            flagN;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fault_retry_sup #(.NCH(NCH), .NGLB(NGLB), .RETRY_TICKS(RT), .FLAG_TICKS(FT)) i_fault_retry_sup (
    .clk(clk), .rstN(rstN), .tick(tick), .addrStrap(addrStrap),
    .chanFault(chanFault), .globalFault(globalFault), .chanEn(chanEn), .flagN(flagN)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic pulseTick();
    tick = 1'b1; @(posedge clk); @(negedge clk); tick = 1'b0;
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    idle();
    // R8 reset state
    check("R8 chanEn", int'(chanEn), 3);
    check("R8 flagN", int'(flagN), 1);

    // R2/R4/R6: single-cycle blip on each channel
    for (int ch = 0; ch < NCH; ch++) begin
      chanFault = NCH'(1) << ch;
      idle();
      chanFault = '0;
      check("R2 own off", int'(chanEn[ch]), 0);
      check("R2 other on", int'(chanEn[1-ch]), 1);
      check("R6 flag low", int'(flagN), 0);
      for (int i = 1; i <= RT; i++) begin
        pulseTick();
        check("R4 retry timing", int'(chanEn[ch]), (i == RT) ? 1 : 0);
        check("R6 flag stretch", int'(flagN), (i < FT) ? 0 : 1);
      end
      pulseTick();
      check("R5 stays on", int'(chanEn), 3);
      check("R5 flag idle", int'(flagN), 1);
    end

    // R5: fault held through k failed retries
    for (int k = 0; k < 3; k++) begin
      chanFault = 2'b01;
      idle();
      check("R2 held off", int'(chanEn[0]), 0);
      for (int r = 0; r < k; r++) begin
        repeat (RT) pulseTick();
        check("R4 retry on", int'(chanEn[0]), 1);
        pulseTick();
        check("R5 failed retry off", int'(chanEn[0]), 0);
        check("R6 flag on failed retry", int'(flagN), 0);
      end
      repeat (RT - 1) pulseTick();
      check("R4 still off", int'(chanEn[0]), 0);
      pulseTick();
      check("R4 retry on", int'(chanEn[0]), 1);
      chanFault = '0;
      pulseTick();
      check("R5 recovered", int'(chanEn[0]), 1);
      repeat (FT) pulseTick();
      check("R6 flag idle", int'(flagN), 1);
    end

    // R3: each global fault bit alone
    for (int g = 0; g < NGLB; g++) begin
      globalFault = NGLB'(1) << g;
      idle();
      globalFault = '0;
      check("R3 both off", int'(chanEn), 0);
      repeat (RT) pulseTick();
      check("R3 both retried", int'(chanEn), 3);
      pulseTick();
      check("R3 both on", int'(chanEn), 3);
      repeat (FT) pulseTick();
    end

    // R7: second event restarts indicator
    chanFault = 2'b01; idle(); chanFault = '0;
    repeat (FT - 1) pulseTick();
    check("R7 flag before", int'(flagN), 0);
    chanFault = 2'b10; idle(); chanFault = '0;
    for (int i = 1; i <= FT; i++) begin
      pulseTick();
      check("R7 restarted", int'(flagN), (i < FT) ? 0 : 1);
    end
    repeat (2 * RT) pulseTick();
    check("R7 both back", int'(chanEn), 3);

    // R1: inactive strap values ignore faults
    for (int s = 1; s < 4; s++) begin
      addrStrap = 2'(s);
      chanFault = '1;
      globalFault = '1;
      idle();
      pulseTick();
      check("R1 enables", int'(chanEn), 3);
      check("R1 flag", int'(flagN), 1);
      chanFault = '0;
      globalFault = '0;
    end
    addrStrap = 2'b00;
    idle();

    // R9: leave standalone mid-retry
    chanFault = 2'b10; idle(); chanFault = '0;
    repeat (2) pulseTick();
    check("R9 off before", int'(chanEn[1]), 0);
    addrStrap = 2'b01; idle();
    check("R9 forced on", int'(chanEn), 3);
    check("R9 flag released", int'(flagN), 1);
    addrStrap = 2'b00;
    for (int i = 0; i < RT + 2; i++) begin
      pulseTick();
      check("R9 stays on", int'(chanEn), 3);
    end
    check("R9 flag idle", int'(flagN), 1);

    done = 1'b1;
    finishRun();
  end

endmodule